// File: doc/BRIEF.md
# Bus Hold Arbiter

This block lets an external master borrow the external memory bus. The outside device pulls an active-low hold request. The arbiter then stops handing new bus cycles to the internal sequencer and waits for any cycle already running to finish. After that it answers with an active-low hold acknowledge, and from then on the sequencer's grant stays low and its bus drivers stay tristated. If the internal side wants the bus while it is lent out, the arbiter raises an active-low bus-request output. That output keeps its level until the external master lets go of the bus.

A single enable bit switches the protocol on. While the bit is set, the three pins involved (hold request, acknowledge and bus request) are forced into their hold functions. Any write that tries to change their port configuration is dropped. When the bit is clear, the hold request input is ignored and the configuration register accepts writes.

Top module: `bus_hold_arb`

## Requirements
- R1: After reset, `hlda_n_o` and `breq_n_o` are 1, `grant_o` is 1 and `cfg_q_o` is all zeros.
- R2: With the enable bit set, the sequencer idle and no other request, `hlda_n_o` goes low on the fourth rising edge after `hold_n_i` falls. That is SYNC_STAGES+2 edges: two synchronizer flops, one clock to stop granting, one clock to hand over.
- R3: The hold is granted only at a cycle boundary. `hlda_n_o` never falls in the clock after one in which `cyc_busy_i` was high. If a cycle is still running, the acknowledge follows on the first edge at which `cyc_busy_i` is low.
- R4: `grant_o` goes low on the third edge after `hold_n_i` falls and stays low for as long as `hlda_n_o` is low.
- R5: `breq_n_o` is low only while `hlda_n_o` is low. If `req_pend_i` is already high when the hold is taken, `breq_n_o` falls on the same edge as `hlda_n_o`. Otherwise it falls on the edge that samples `req_pend_i` high.
- R6: Once `breq_n_o` is low, it stays low until the hold ends, even if `req_pend_i` drops.
- R7: On the third edge after `hold_n_i` rises (SYNC_STAGES+1), `hlda_n_o` and `breq_n_o` return to 1 and `grant_o` returns to 1.
- R8: While the enable bit is clear, `hold_n_i` has no effect, and `hlda_n_o` and `grant_o` stay at 1.
- R9: A configuration write (`cfg_we_i`) loads `cfg_wdata_i` into `cfg_q_o` on the next edge only when the enable bit is clear. Writes made while the bit is set are dropped.
- R10: `pin_sel_o` is all ones while the enable bit is set, and otherwise equals `cfg_q_o`. Bit 0 selects the hold-request pin, bit 1 the acknowledge pin and bit 2 the bus-request pin, and a 1 means the pin takes its hold role.
- R11: Clearing the enable bit during a hold brings `hlda_n_o`, `breq_n_o` and `grant_o` back to 1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_en_i | input | 1 | Bus-hold protocol enable bit |
| hold_n_i | input | 1 | Asynchronous active-low hold request from the external master |
| req_pend_i | input | 1 | Sequencer has an external cycle pending |
| cyc_busy_i | input | 1 | Sequencer has a bus cycle in progress |
| cfg_we_i | input | 1 | Port configuration write strobe |
| cfg_wdata_i | input | PIN_W | Port configuration write data |
| hlda_n_o | output | 1 | Active-low hold acknowledge |
| breq_n_o | output | 1 | Active-low bus request during a hold |
| grant_o | output | 1 | Sequencer may start cycles and drive the bus |
| cfg_q_o | output | PIN_W | Stored port configuration |
| pin_sel_o | output | PIN_W | Per-pin hold-role select |

## Verification
Each result has a fixed delay after its stimulus. The acknowledge is due four edges after the hold request falls, or on the first edge after the running cycle ends if that comes later. The grant drops on the third edge, and release takes three edges. The bus request follows the acknowledge edge or the edge that samples the pending request, and enable and configuration effects appear one edge after they are applied. The bench drives every input shortly after a rising edge. It then counts the edges from that drive and samples the outputs two time units after each edge. For every sampled edge it works out the expected level of each output from the edge number, the length of the busy period and the timing of the pending request.

// File: rtl/bha_pkg.sv
package bha_pkg;

  typedef enum logic [1:0] {
    ARB_OWN   = 2'd0,
    ARB_DRAIN = 2'd1,
    ARB_HELD  = 2'd2
  } arb_st_e;

  // Next arbiter state from current state, enable, synced request, busy.
  function automatic arb_st_e f_arb_next(input arb_st_e st, input logic en,
                                         input logic req, input logic busy);
    arb_st_e n;
    n = st;
    case (st)
      ARB_OWN:   if (en && req) n = ARB_DRAIN;
      ARB_DRAIN: if (!(en && req)) n = ARB_OWN;
                 else if (!busy) n = ARB_HELD;
      ARB_HELD:  if (!(en && req)) n = ARB_OWN;
      default:   n = ARB_OWN;
    endcase
    return n;
  endfunction

  // Sticky bus request: set by pending request while held, kept until release.
  function automatic logic f_breq_next(input logic held_nxt, input logic cur,
                                       input logic pend);
    return held_nxt && (cur || pend);
  endfunction

endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= RST_VAL;
        else        sh_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= {sh_q[LAST-1:0], async_i};
      end
    end
  endgenerate

  assign sync_o = sh_q[LAST];
endmodule

// File: rtl/bha_arb_fsm.sv
module bha_arb_fsm
  import bha_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hold_en_i,
  input  logic    hold_req_i,
  input  logic    cyc_busy_i,
  output arb_st_e st_o,
  output logic    held_nxt_o
);
  arb_st_e st_q, st_d;

  always_comb st_d = f_arb_next(st_q, hold_en_i, hold_req_i, cyc_busy_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ARB_OWN;
    else        st_q <= st_d;
  end

  assign st_o       = st_q;
  assign held_nxt_o = (st_d == ARB_HELD);
endmodule

// File: rtl/bha_breq_latch.sv
module bha_breq_latch
  import bha_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic held_nxt_i,
  input  logic req_pend_i,
  output logic breq_o
);
  logic breq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) breq_q <= 1'b0;
    else        breq_q <= f_breq_next(held_nxt_i, breq_q, req_pend_i);
  end

  assign breq_o = breq_q;
endmodule

// File: rtl/bha_pin_lock.sv
module bha_pin_lock #(
  parameter int PIN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_en_i,
  input  logic             we_i,
  input  logic [PIN_W-1:0] wdata_i,
  output logic [PIN_W-1:0] cfg_q_o,
  output logic [PIN_W-1:0] pin_sel_o
);
  logic [PIN_W-1:0] cfg_q;
  logic             wr_ok;

  assign wr_ok = we_i && !hold_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_ok) cfg_q <= wdata_i;
  end

  generate
    for (genvar i = 0; i < PIN_W; i++) begin : g_sel
      assign pin_sel_o[i] = hold_en_i | cfg_q[i];
    end
  endgenerate

  assign cfg_q_o = cfg_q;
endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb
  import bha_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PIN_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_en_i,
  input  logic             hold_n_i,
  input  logic             req_pend_i,
  input  logic             cyc_busy_i,
  input  logic             cfg_we_i,
  input  logic [PIN_W-1:0] cfg_wdata_i,
  output logic             hlda_n_o,
  output logic             breq_n_o,
  output logic             grant_o,
  output logic [PIN_W-1:0] cfg_q_o,
  output logic [PIN_W-1:0] pin_sel_o
);
  logic    hold_n_s;
  logic    hold_req_s;
  logic    held_nxt;
  logic    breq_s;
  arb_st_e st;

  bha_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(hold_n_i), .sync_o(hold_n_s)
  );

  assign hold_req_s = ~hold_n_s;

  bha_arb_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hold_en_i(hold_en_i), .hold_req_i(hold_req_s),
    .cyc_busy_i(cyc_busy_i), .st_o(st), .held_nxt_o(held_nxt)
  );

  bha_breq_latch u_breq (
    .clk(clk), .rst_n(rst_n), .held_nxt_i(held_nxt), .req_pend_i(req_pend_i),
    .breq_o(breq_s)
  );

  bha_pin_lock #(.PIN_W(PIN_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .hold_en_i(hold_en_i), .we_i(cfg_we_i),
    .wdata_i(cfg_wdata_i), .cfg_q_o(cfg_q_o), .pin_sel_o(pin_sel_o)
  );

  assign hlda_n_o = (st != ARB_HELD);
  assign grant_o  = (st == ARB_OWN);
  assign breq_n_o = ~breq_s;
endmodule

// File: rtl/bus_hold_arb_chk.sv
module bus_hold_arb_chk #(
  parameter int PIN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold_en_i,
  input logic             cyc_busy_i,
  input logic             hold_req_s,
  input logic             hlda_n_o,
  input logic             breq_n_o,
  input logic             grant_o,
  input logic [PIN_W-1:0] cfg_q_o
);
  a_r4_grant_off_held: assert property (@(posedge clk) disable iff (!rst_n)
    !hlda_n_o |-> !grant_o);

  a_r5_breq_needs_hlda: assert property (@(posedge clk) disable iff (!rst_n)
    !breq_n_o |-> !hlda_n_o);

  a_r6_breq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!breq_n_o && hold_req_s && hold_en_i) |=> !breq_n_o);

  a_r3_cycle_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda_n_o) |-> $past(!cyc_busy_i));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!hlda_n_o && !hold_req_s) |=> hlda_n_o);

  a_r8_disabled_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_en_i |=> (hlda_n_o && grant_o));

  a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    hold_en_i |=> $stable(cfg_q_o));
endmodule

bind bus_hold_arb bus_hold_arb_chk #(.PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_en_i(hold_en_i), .cyc_busy_i(cyc_busy_i),
  .hold_req_s(hold_req_s), .hlda_n_o(hlda_n_o), .breq_n_o(breq_n_o),
  .grant_o(grant_o), .cfg_q_o(cfg_q_o)
);

// File: tb/bus_hold_arb_tb_top.sv
`timescale 1ns/1ps
module bus_hold_arb_tb_top;
  localparam int SYNC = 2;
  localparam int PW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_en = 1'b0, hold_n = 1'b1, req_pend = 1'b0, busy = 1'b0, cfg_we = 1'b0;
  logic [PW-1:0] cfg_wd = '0;
  logic hlda_n, breq_n, grant;
  logic [PW-1:0] cfg_q, pin_sel;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_hold_arb #(.SYNC_STAGES(SYNC), .PIN_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hold_en_i(hold_en), .hold_n_i(hold_n),
    .req_pend_i(req_pend), .cyc_busy_i(busy), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wd), .hlda_n_o(hlda_n), .breq_n_o(breq_n),
    .grant_o(grant), .cfg_q_o(cfg_q), .pin_sel_o(pin_sel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int h, rel;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 hlda", 8'(hlda_n), 8'd1);
    chk("R1 breq", 8'(breq_n), 8'd1);
    chk("R1 grant", 8'(grant), 8'd1);
    chk("R1 cfg", 8'(cfg_q), 8'd0);

    // R8 disabled: hold request ignored
    hold_n = 1'b0;
    for (int e = 1; e <= 8; e++) begin
      tick();
      chk("R8 hlda", 8'(hlda_n), 8'd1);
      chk("R8 grant", 8'(grant), 8'd1);
    end
    hold_n = 1'b1;
    repeat (4) tick();

    // R9/R10 configuration lock
    cfg_we = 1'b1; cfg_wd = 3'b101;
    tick();
    cfg_we = 1'b0;
    chk("R9 write unlocked", 8'(cfg_q), 8'h5);
    chk("R10 sel follows cfg", 8'(pin_sel), 8'h5);
    hold_en = 1'b1;
    #1;
    chk("R10 sel forced", 8'(pin_sel), 8'h7);
    cfg_we = 1'b1; cfg_wd = 3'b010;
    tick();
    cfg_we = 1'b0;
    chk("R9 write locked", 8'(cfg_q), 8'h5);
    chk("R10 sel forced", 8'(pin_sel), 8'h7);

    // Sweep: busy length x pending pattern (R2..R7)
    for (int bl = 0; bl <= 6; bl++) begin
      for (int rp = 0; rp <= 2; rp++) begin
        h = (bl + 1 > SYNC + 2) ? bl + 1 : SYNC + 2;
        busy = (bl > 0);
        req_pend = (rp == 1);
        hold_n = 1'b0;
        for (int e = 1; e <= h + 5; e++) begin
          logic eb;
          tick();
          eb = 1'b1;
          if (rp == 1 && e >= h) eb = 1'b0;
          if (rp == 2 && e >= h + 2) eb = 1'b0;
          chk((bl > 0) ? "R3 hlda" : "R2 hlda", 8'(hlda_n), (e >= h) ? 8'd1 - 8'd1 : 8'd1);
          chk("R4 grant", 8'(grant), (e >= SYNC + 1) ? 8'd0 : 8'd1);
          chk((rp == 2 && e >= h + 3) ? "R6 breq" : "R5 breq", 8'(breq_n), 8'(eb));
          if (bl > 0 && e == bl) busy = 1'b0;
          if (rp == 2 && e == h + 1) req_pend = 1'b1;
          if (rp == 2 && e == h + 2) req_pend = 1'b0;
        end
        hold_n = 1'b1;
        rel = SYNC + 1;
        for (int e = 1; e <= rel; e++) begin
          tick();
          chk("R7 hlda", 8'(hlda_n), (e >= rel) ? 8'd1 : 8'd0);
          chk("R7 breq", 8'(breq_n), (e >= rel || rp == 0) ? 8'd1 : 8'd0);
          chk("R7 grant", 8'(grant), (e >= rel) ? 8'd1 : 8'd0);
        end
        req_pend = 1'b0;
        tick();
      end
    end

    // R11 clearing enable during a hold
    req_pend = 1'b1;
    hold_n = 1'b0;
    repeat (SYNC + 3) tick();
    chk("R11 held", 8'(hlda_n), 8'd0);
    chk("R11 breq on", 8'(breq_n), 8'd0);
    hold_en = 1'b0;
    tick();
    chk("R11 hlda", 8'(hlda_n), 8'd1);
    chk("R11 breq", 8'(breq_n), 8'd1);
    chk("R11 grant", 8'(grant), 8'd1);
    chk("R10 sel unlocked", 8'(pin_sel), 8'h5);
    hold_n = 1'b1; req_pend = 1'b0;
    repeat (4) tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule